// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides, for one memory access at a time, whether the access may bypass page translation. It holds a small set of programmable address windows (two by default, called window 0 and window 1). Each window compares the top byte of the 32-bit logical address against a base value, with a mask that turns chosen bits into don't-cares. Each window also carries a privilege filter, an enable bit, a write-protect flag and a two-bit attribute field. When a window accepts the access, the physical address is the logical address unchanged.

If more than one window accepts the access, window 0 supplies the status bits. A write or read-modify-write that lands in a write-protected window raises a protection fault in the same cycle, and no physical address is delivered.

Two copies are intended for each core: one on the instruction-fetch side and one on the operand side. Each copy is programmed on its own. Window registers change only on a clock edge through the write port. The match decision is purely combinational from the stored fields and the current access.

Top module: `ttw_matcher`

## Requirements
- R1: After reset, every window is disabled, so no access hits (`tt_hit`=0, `pa_valid`=0, `pa`=0).
- R2: When `cfg_we`=1 at a rising clock edge, window `cfg_sel` is loaded from `cfg_data`. The layout is: [7:0] base, [15:8] mask, [16] enable, [18:17] privilege filter, [19] write protect, [21:20] attribute. The new value is used from that edge on, and not before it.
- R3: A window hits only when every address bit [31:24] whose mask bit is 0 equals the matching base bit. A mask of 0xFF accepts every address, and base 0x00 with mask 0x0F accepts 0x00000000 through 0x0FFFFFFF.
- R4: The privilege filter works as follows: code 0 accepts only user accesses (`acc_sup`=0), code 1 only supervisor accesses (`acc_sup`=1), and codes 2 and 3 accept both.
- R5: A window whose enable bit is 0 never hits, whatever its other fields hold.
- R6: When an access hits and does not fault, `pa_valid`=1 and `pa` equals `la`.
- R7: When several windows hit, `tt_wp` and `tt_attr` come from the lowest-numbered hitting window. When only one window hits, they come from that window.
- R8: Access kind encoding is 0 read, 1 write, 2 read-modify-write, 3 read. A write or read-modify-write whose selected window has write protect set drives `prot_fault`=1, `pa_valid`=0 and `pa`=0 in the same cycle.
- R9: A read that hits a write-protected window is translated normally, without a fault.
- R10: When no window hits: `tt_wp`=0, `tt_attr`=0, `prot_fault`=0, `pa_valid`=0 and `pa`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 1 | Index of the window to write |
| cfg_data | input | 22 | Window register contents (layout in R2) |
| la | input | 32 | Logical address of the access |
| acc_sup | input | 1 | 1 = supervisor access, 0 = user access |
| acc_kind | input | 2 | Access kind (encoding in R8) |
| tt_hit | output | 1 | Some enabled window accepted the access |
| tt_wp | output | 1 | Write-protect flag of the selected window |
| tt_attr | output | 2 | Attribute bits of the selected window |
| prot_fault | output | 1 | Write or read-modify-write into a protected window |
| pa_valid | output | 1 | `pa` carries a usable physical address |
| pa | output | 32 | Physical address (equal to `la` when valid) |

## Verification
The hardest situation to reach is the one where both windows accept the same access but disagree on write protection. For example, window 0 is unprotected while window 1 is protected, so a write must pass, even though a priority error would make it fault (and the reverse case must fault).

The stimulus loads six window pairs built so that they overlap in shifted, masked and privilege-filtered ways. For each pair it sweeps every top address byte against both privilege levels and all four access kinds. The expected status, fault and address are computed arithmetically from the programmed fields.

// File: rtl/ttw_pkg.sv
package ttw_pkg;

    localparam int CMP_W  = 8;
    localparam int ATTR_W = 2;

    // privilege filter codes
    typedef enum logic [1:0] {
        PSEL_USER  = 2'd0,
        PSEL_SUPER = 2'd1,
        PSEL_ANY   = 2'd2,
        PSEL_ANY2  = 2'd3
    } psel_e;

    // access kind codes
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_RMW   = 2'd2,
        ACC_READ2 = 2'd3
    } acc_e;

    // one window register; packed order equals cfg_data layout (msb first)
    typedef struct packed {
        logic [ATTR_W-1:0] attr;
        logic              wp;
        psel_e             psel;
        logic              en;
        logic [CMP_W-1:0]  mask;
        logic [CMP_W-1:0]  base;
    } win_cfg_t;

    localparam int CFG_W = $bits(win_cfg_t);

endpackage

// File: rtl/ttw_regs.sv
module ttw_regs
    import ttw_pkg::*;
#(
    parameter int NUM_WIN = 2,
    localparam int SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    output win_cfg_t         cfg [NUM_WIN]
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[g] <= '0;
            end else if (cfg_we && (cfg_sel == SEL_W'(g))) begin
                cfg[g] <= win_cfg_t'(cfg_data);
            end
        end
    end

endmodule

// File: rtl/ttw_cmp.sv
module ttw_cmp
    import ttw_pkg::*;
(
    input  logic             en,
    input  logic [CMP_W-1:0] base,
    input  logic [CMP_W-1:0] mask,
    input  psel_e            psel,
    input  logic [CMP_W-1:0] la_top,
    input  logic             acc_sup,
    output logic             hit
);

    logic addr_ok;
    logic priv_ok;

    assign addr_ok = (((la_top ^ base) & ~mask) == '0);

    always_comb begin
        unique case (psel)
            PSEL_USER:  priv_ok = !acc_sup;
            PSEL_SUPER: priv_ok = acc_sup;
            default:    priv_ok = 1'b1;
        endcase
    end

    assign hit = en && addr_ok && priv_ok;

endmodule

// File: rtl/ttw_pick.sv
module ttw_pick
    import ttw_pkg::*;
#(
    parameter int NUM_WIN = 2
) (
    input  logic [NUM_WIN-1:0] hit_vec,
    input  logic [NUM_WIN-1:0] wp_vec,
    input  logic [ATTR_W-1:0]  attr_vec [NUM_WIN],
    input  acc_e               acc_kind,
    output logic               any_hit,
    output logic               sel_wp,
    output logic [ATTR_W-1:0]  sel_attr,
    output logic               fault
);

    logic is_store;

    always_comb begin
        sel_wp   = 1'b0;
        sel_attr = '0;
        // walk downward so the lowest index wins
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_wp   = wp_vec[i];
                sel_attr = attr_vec[i];
            end
        end
    end

    always_comb begin
        unique case (acc_kind)
            ACC_WRITE, ACC_RMW: is_store = 1'b1;
            default:            is_store = 1'b0;
        endcase
    end

    assign any_hit = |hit_vec;
    assign fault   = any_hit && sel_wp && is_store;

endmodule

// File: rtl/ttw_matcher.sv
module ttw_matcher
    import ttw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 2,
    localparam int SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic [ADDR_W-1:0] la,
    input  logic              acc_sup,
    input  logic [1:0]        acc_kind,
    output logic              tt_hit,
    output logic              tt_wp,
    output logic [ATTR_W-1:0] tt_attr,
    output logic              prot_fault,
    output logic              pa_valid,
    output logic [ADDR_W-1:0] pa
);

    win_cfg_t            cfg [NUM_WIN];
    logic [NUM_WIN-1:0]  hit_vec;
    logic [NUM_WIN-1:0]  wp_vec;
    logic [ATTR_W-1:0]   attr_vec [NUM_WIN];
    logic [CMP_W-1:0]    la_top;

    assign la_top = la[ADDR_W-1 -: CMP_W];

    ttw_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .cfg      (cfg)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign wp_vec[g]   = cfg[g].wp;
        assign attr_vec[g] = cfg[g].attr;

        ttw_cmp u_cmp (
            .en      (cfg[g].en),
            .base    (cfg[g].base),
            .mask    (cfg[g].mask),
            .psel    (cfg[g].psel),
            .la_top  (la_top),
            .acc_sup (acc_sup),
            .hit     (hit_vec[g])
        );
    end

    ttw_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .hit_vec  (hit_vec),
        .wp_vec   (wp_vec),
        .attr_vec (attr_vec),
        .acc_kind (acc_e'(acc_kind)),
        .any_hit  (tt_hit),
        .sel_wp   (tt_wp),
        .sel_attr (tt_attr),
        .fault    (prot_fault)
    );

    assign pa_valid = tt_hit && !prot_fault;
    assign pa       = pa_valid ? la : '0;

endmodule

// File: rtl/ttw_matcher_chk.sv
module ttw_matcher_chk #(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] la,
    input logic [1:0]        acc_kind,
    input logic              tt_hit,
    input logic              tt_wp,
    input logic [ATTR_W-1:0] tt_attr,
    input logic              prot_fault,
    input logic              pa_valid,
    input logic [ADDR_W-1:0] pa
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tt_hit && !pa_valid);

    p_pa_identity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pa_valid |-> (pa == la) && tt_hit);

    p_fault_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> tt_hit && tt_wp && (acc_kind == 2'd1 || acc_kind == 2'd2)
                       && !pa_valid && (pa == '0));

    p_read_no_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd0 || acc_kind == 2'd3) |-> !prot_fault);

    p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tt_hit |-> !pa_valid && !tt_wp && (tt_attr == '0) && (pa == '0) && !prot_fault);

endmodule

bind ttw_matcher ttw_matcher_chk #(.ADDR_W(ADDR_W), .ATTR_W(ttw_pkg::ATTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .la         (la),
    .acc_kind   (acc_kind),
    .tt_hit     (tt_hit),
    .tt_wp      (tt_wp),
    .tt_attr    (tt_attr),
    .prot_fault (prot_fault),
    .pa_valid   (pa_valid),
    .pa         (pa)
);

// File: tb/sim_ttw_matcher.sv
`timescale 1ns/1ps
module sim_ttw_matcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [21:0] cfg_data = '0;
    logic [31:0] la = '0;
    logic        acc_sup = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        tt_hit, tt_wp, prot_fault, pa_valid;
    logic [1:0]  tt_attr;
    logic [31:0] pa;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] lfsr = 24'h5A3C91;

    // bench model of the two windows
    logic       m_en   [2];
    logic [7:0] m_base [2];
    logic [7:0] m_mask [2];
    logic [1:0] m_psel [2];
    logic       m_wp   [2];
    logic [1:0] m_attr [2];

    always #2.5 clk = ~clk;   // 200 MHz

    ttw_matcher u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .la(la), .acc_sup(acc_sup), .acc_kind(acc_kind),
        .tt_hit(tt_hit), .tt_wp(tt_wp), .tt_attr(tt_attr),
        .prot_fault(prot_fault), .pa_valid(pa_valid), .pa(pa)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // R2 layout: [7:0] base [15:8] mask [16] en [18:17] psel [19] wp [21:20] attr
    task automatic wcfg(input int s, input logic en, input logic [7:0] base,
                        input logic [7:0] mask, input logic [1:0] psel,
                        input logic wp, input logic [1:0] attr);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = 1'(s);
        cfg_data = {attr, wp, psel, en, mask, base};
        @(negedge clk);
        cfg_we   = 1'b0;
        m_en[s] = en; m_base[s] = base; m_mask[s] = mask;
        m_psel[s] = psel; m_wp[s] = wp; m_attr[s] = attr;
    endtask

    function automatic logic mhit(input int s, input logic [7:0] top, input logic sup);
        logic pok;
        pok = (m_psel[s] == 2'd0) ? !sup : (m_psel[s] == 2'd1) ? sup : 1'b1;
        return m_en[s] && (((top ^ m_base[s]) & ~m_mask[s]) == 8'h00) && pok;
    endfunction

    task automatic apply(input logic [31:0] a, input logic sup, input logic [1:0] k);
        @(negedge clk);
        la = a; acc_sup = sup; acc_kind = k;
        #1;
    endtask

    task automatic sweep();
        for (int t = 0; t < 256; t++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 4; k++) begin
                    logic h0, h1, h, w, st, f, v;
                    logic [1:0] at;
                    logic [31:0] a;
                    lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
                    a  = {8'(t), lfsr};
                    apply(a, 1'(s), 2'(k));
                    h0 = mhit(0, 8'(t), 1'(s));
                    h1 = mhit(1, 8'(t), 1'(s));
                    h  = h0 | h1;
                    w  = h ? (h0 ? m_wp[0] : m_wp[1]) : 1'b0;
                    at = h ? (h0 ? m_attr[0] : m_attr[1]) : 2'b00;
                    st = (k == 1) || (k == 2);
                    f  = h && w && st;
                    v  = h && !f;
                    chk("R3 R4 R5 hit", 64'(tt_hit), 64'(h));
                    chk("R7 status", 64'({tt_wp, tt_attr}), 64'({w, at}));
                    chk("R8 R9 fault", 64'(prot_fault), 64'(f));
                    chk("R6 R10 pa", 64'({pa_valid, pa}), 64'({v, (v ? a : 32'h0)}));
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_en[s] = 0; m_base[s] = 0; m_mask[s] = 0;
            m_psel[s] = 0; m_wp[s] = 0; m_attr[s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: nothing hits after reset
        apply(32'h0000_1000, 1'b0, 2'd0);
        chk("R1 hit", 64'(tt_hit), 64'd0);
        chk("R1 pa", 64'({pa_valid, pa}), 64'd0);

        // R2: write not visible before its edge, visible after
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0;
        cfg_data = {2'd2, 1'b0, 2'd2, 1'b1, 8'hFF, 8'h00};
        la = 32'h1234_5678; acc_sup = 1'b1; acc_kind = 2'd0;
        #1;
        chk("R2 before edge", 64'(tt_hit), 64'd0);
        @(negedge clk); cfg_we = 1'b0;
        m_en[0] = 1; m_base[0] = 0; m_mask[0] = 8'hFF; m_psel[0] = 2; m_wp[0] = 0; m_attr[0] = 2;
        #1;
        chk("R2 after edge", 64'({tt_hit, tt_attr}), 64'({1'b1, 2'd2}));

        // R4: user-only window
        wcfg(0, 1'b1, 8'h20, 8'h00, 2'd0, 1'b0, 2'd1);
        apply(32'h2000_0040, 1'b1, 2'd0);
        chk("R4 super rejected", 64'(tt_hit), 64'd0);
        apply(32'h2000_0040, 1'b0, 2'd0);
        chk("R4 user accepted", 64'(tt_hit), 64'd1);

        // R5: disabled all-accepting window never hits
        wcfg(0, 1'b0, 8'h00, 8'hFF, 2'd2, 1'b1, 2'd3);
        apply(32'hDEAD_BEEF, 1'b1, 2'd1);
        chk("R5 disabled", 64'({tt_hit, prot_fault}), 64'd0);

        // R3 example window with write protect, R8 and R9
        wcfg(0, 1'b1, 8'h00, 8'h0F, 2'd1, 1'b1, 2'd1);
        apply(32'h0FFF_FFFF, 1'b1, 2'd0);
        chk("R9 read protected", 64'({pa_valid, prot_fault, pa}), 64'({2'b10, 32'h0FFF_FFFF}));
        apply(32'h0FFF_FFFF, 1'b1, 2'd2);
        chk("R8 rmw protected", 64'({pa_valid, prot_fault, pa}), 64'({2'b01, 32'h0}));
        apply(32'h1000_0000, 1'b1, 2'd1);
        chk("R3 R10 outside", 64'({tt_hit, prot_fault, tt_wp}), 64'd0);

        // sweeps over six window pairs
        wcfg(1, 1'b0, 8'h00, 8'h00, 2'd0, 1'b0, 2'd0);
        sweep();
        wcfg(0, 1'b1, 8'h00, 8'hFF, 2'd0, 1'b0, 2'd2);
        wcfg(1, 1'b1, 8'h40, 8'h3F, 2'd2, 1'b1, 2'd3);
        sweep();
        wcfg(0, 1'b1, 8'hA5, 8'h00, 2'd3, 1'b0, 2'd0);
        wcfg(1, 1'b1, 8'hA0, 8'h0F, 2'd1, 1'b1, 2'd1);
        sweep();
        wcfg(0, 1'b0, 8'h00, 8'hFF, 2'd2, 1'b1, 2'd3);
        wcfg(1, 1'b1, 8'h80, 8'h7F, 2'd0, 1'b0, 2'd2);
        sweep();
        wcfg(0, 1'b1, 8'h33, 8'hC0, 2'd3, 1'b1, 2'd3);
        wcfg(1, 1'b1, 8'h00, 8'hFF, 2'd2, 1'b0, 2'd1);
        sweep();
        wcfg(0, 1'b1, 8'h10, 8'h01, 2'd1, 1'b0, 2'd1);
        wcfg(1, 1'b1, 8'h10, 8'h01, 2'd1, 1'b1, 2'd2);
        sweep();

        summary();
        $finish;
    end

endmodule